// File: doc/BRIEF.md
# Crate Controller Host Register Interface and Dataway Cycle Sequencer

This block sits between a byte-wide host port and the dataway of an instrument crate. The host selects one of sixteen internal locations with four address lines. It qualifies every access with an active-low enable, a read/write select and a write strobe. Through these locations it assembles a 24-bit write word from three bytes and loads the station number, subaddress and function code. It also sets the initialize, clear, inhibit and auxiliary-inhibit-hold control bits.

A write to the trigger location starts one dataway cycle. The cycle runs a fixed sequence: a setup phase that drives the command, a first strobe phase in which the response is sampled, and a second strobe phase. When the cycle completes, the block holds the 24-bit read word together with the Q and X responses for the host. It clears the initialize and clear bits and raises a cycle-complete status bit. The 23 station attention (LAM) inputs are priority-encoded at all times, and the result is readable beside Q and X.

Top module: `crate_regif_top`

## Requirements
- R1: A host write to address 0, 1 or 2 loads bits 23:16, 15:8 or 7:0 of `dw_wdata`. The new value appears after the clock edge that samples the write.
- R2: Host writes to address 3, 4 and 5 load `dw_a` (4 bits), `dw_f` (5 bits) and `dw_n` (5 bits) from the low bits of the write byte.
- R3: A host write to address 6 loads the control bits from the write byte: bit 0 to `dw_z`, bit 1 to `dw_c`, bit 2 to `dw_i` and bit 3 to `dw_aux_hold`.
- R4: A host write to address 7 while idle starts a cycle. `dw_busy` rises at the sampling edge. `dw_s1` is high for T_S1 cycles after T_SETUP cycles, and `dw_s2` follows directly for T_S2 cycles. `dw_busy` falls T_SETUP+T_S1+T_S2 edges after the trigger edge.
- R5: `dw_rdata`, `dw_q` and `dw_x` are captured on the last edge of the first strobe phase. Reads of address 9, 10 and 11 return bits 23:16, 15:8 and 7:0 of the captured word. Address 8 returns Q in bit 7 and X in bit 6.
- R6: `dw_z` and `dw_c` return to 0 at the edge that ends a cycle. `dw_i` and `dw_aux_hold` keep their values.
- R7: Status at address 12 holds cycle-complete in bit 0, which is set at cycle end and cleared at the edge that starts the next cycle. Bit 1 follows `aux_state`. The other bits are 0.
- R8: `dw_lam[k]` is the LAM of station k+1. Address 8 bits 4:0 give the lowest-numbered asserted station, or 0 when none is asserted. Bit 5 and `lam_flag` are 1 whenever any LAM is asserted.
- R9: A trigger write that arrives while a cycle is in progress is ignored, and the running cycle ends at its original time.
- R10: An access with `host_en_n` high, or with `host_rd_wn` high, changes no register. `host_rdata` is 0 unless a read is enabled. Addresses 0–7 and 13–15 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_en_n | input | 1 | Active-low host access enable |
| host_rd_wn | input | 1 | 1 = read, 0 = write |
| host_wstb | input | 1 | Write strobe, sampled at the clock edge |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (combinational) |
| dw_n | output | 5 | Station number to the dataway |
| dw_a | output | 4 | Subaddress to the dataway |
| dw_f | output | 5 | Function code to the dataway |
| dw_wdata | output | 24 | Write word to the dataway |
| dw_rdata | input | 24 | Read word from the dataway |
| dw_q | input | 1 | Q response |
| dw_x | input | 1 | X response |
| dw_s1 | output | 1 | First strobe |
| dw_s2 | output | 1 | Second strobe |
| dw_busy | output | 1 | Cycle in progress |
| dw_z | output | 1 | Initialize request |
| dw_c | output | 1 | Clear request |
| dw_i | output | 1 | Inhibit |
| dw_aux_hold | output | 1 | Auxiliary inhibit hold |
| dw_lam | input | 23 | Station LAM lines, bit k = station k+1 |
| aux_state | input | 1 | Auxiliary controller state |
| lam_flag | output | 1 | Any LAM asserted |

## Verification
A register write shows on the dataway outputs after the single edge that samples it. Reads are combinational, so the bench applies the address at a falling edge and samples 1 ns later. After a trigger edge, the bench counts falling edges: `dw_busy` is due at the first one, `dw_s1` T_SETUP edges later, `dw_s2` T_S1 edges after that, and the end of the cycle, with Z and C cleared and complete set, T_S2 edges after that. The bench changes the dataway response inputs once the second strobe phase has begun. This shows that capture took place on the last edge of the first phase. The ignore test fires a second trigger one edge into the cycle and checks busy on both sides of the original end edge.

// File: rtl/crate_regif_pkg.sv
// Package: shared constants and the sequencer state type for the crate
// controller host register interface.
package crate_regif_pkg;

    localparam int unsigned HOST_AW  = 4;
    localparam int unsigned HOST_DW  = 8;
    localparam int unsigned WORD_W   = 24;
    localparam int unsigned SUBA_W   = 4;
    localparam int unsigned FUNC_W   = 5;

    localparam logic [HOST_AW-1:0] AD_WHI   = 4'd0;
    localparam logic [HOST_AW-1:0] AD_WMID  = 4'd1;
    localparam logic [HOST_AW-1:0] AD_WLO   = 4'd2;
    localparam logic [HOST_AW-1:0] AD_SUBA  = 4'd3;
    localparam logic [HOST_AW-1:0] AD_FUNC  = 4'd4;
    localparam logic [HOST_AW-1:0] AD_STAT  = 4'd5;
    localparam logic [HOST_AW-1:0] AD_CTRL  = 4'd6;
    localparam logic [HOST_AW-1:0] AD_GO    = 4'd7;
    localparam logic [HOST_AW-1:0] AD_RESP  = 4'd8;
    localparam logic [HOST_AW-1:0] AD_RHI   = 4'd9;
    localparam logic [HOST_AW-1:0] AD_RMID  = 4'd10;
    localparam logic [HOST_AW-1:0] AD_RLO   = 4'd11;
    localparam logic [HOST_AW-1:0] AD_STS   = 4'd12;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_SETUP = 2'd1,
        SQ_STB1  = 2'd2,
        SQ_STB2  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/lam_prio_enc.sv
// Module: lam_prio_enc
// Encodes the station attention lines into the number of the lowest
// asserted station (bit k is station k+1), 0 when none, plus an any flag.
// Assumes the LAM lines are already synchronous to clk.
module lam_prio_enc #(
    parameter int unsigned N_ST = 23,
    parameter int unsigned ST_W = $clog2(N_ST + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_ST-1:0] lam,
    output logic            any,
    output logic [ST_W-1:0] code
);

    // Priority scan: the loop runs from the lowest priority upward so the
    // lowest station index is the last and winning assignment.
    always_comb begin
        any  = |lam;
        code = '0;
        for (int k = N_ST - 1; k >= 0; k--) begin
            if (lam[k]) code = ST_W'(k + 1);
        end
    end

    // The encoded station must be asserted and no lower station may be.
    assert_lam_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (lam[code - ST_W'(1)] &&
                 ((lam & ((N_ST'(1) << (code - ST_W'(1))) - N_ST'(1))) == '0)));

    assert_lam_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lam == '0) |-> (code == '0 && !any));

endmodule

// File: rtl/dw_cycle_seq.sv
// Module: dw_cycle_seq
// Runs one dataway cycle per accepted start request as three fixed phases:
// setup, strobe 1, strobe 2. Emits a capture pulse on the last cycle of
// strobe 1 and an end pulse on the last cycle of strobe 2. Holds a
// cycle-complete flag. Assumes every phase length is at least 1.
module dw_cycle_seq
    import crate_regif_pkg::*;
#(
    parameter int unsigned T_SETUP = 2,
    parameter int unsigned T_S1    = 2,
    parameter int unsigned T_S2    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    output logic busy,
    output logic s1,
    output logic s2,
    output logic capture,
    output logic cycle_end,
    output logic done
);

    localparam int unsigned T_MAX = (T_SETUP > T_S1) ?
                                    ((T_SETUP > T_S2) ? T_SETUP : T_S2) :
                                    ((T_S1 > T_S2) ? T_S1 : T_S2);
    localparam int unsigned CW = $clog2(T_MAX) + 1;

    seq_state_e    state;
    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic          phase_last;

    // Select the last count value of the phase in progress.
    always_comb begin
        unique case (state)
            SQ_SETUP: limit = CW'(T_SETUP - 1);
            SQ_STB1:  limit = CW'(T_S1 - 1);
            SQ_STB2:  limit = CW'(T_S2 - 1);
            default:  limit = '0;
        endcase
        phase_last = (state != SQ_IDLE) && (cnt == limit);
    end

    // Phase state machine with per-phase counter and complete flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    cnt <= '0;
                    if (start_req) begin
                        state <= SQ_SETUP;
                        done  <= 1'b0;
                    end
                end
                SQ_SETUP: begin
                    cnt <= phase_last ? '0 : cnt + CW'(1);
                    if (phase_last) state <= SQ_STB1;
                end
                SQ_STB1: begin
                    cnt <= phase_last ? '0 : cnt + CW'(1);
                    if (phase_last) state <= SQ_STB2;
                end
                SQ_STB2: begin
                    cnt <= phase_last ? '0 : cnt + CW'(1);
                    if (phase_last) begin
                        state <= SQ_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Decode the dataway controls from the phase.
    always_comb begin
        busy      = (state != SQ_IDLE);
        s1        = (state == SQ_STB1);
        s2        = (state == SQ_STB2);
        capture   = s1 && phase_last;
        cycle_end = s2 && phase_last;
    end

    assert_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_req) |=> (busy && !done));

    assert_s2_after_s1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s2) |-> $past(s1));

    assert_s1_after_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s1) |-> $past(busy));

    assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start_req) |=> done);

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cycle_end) |=> busy);

endmodule

// File: rtl/dw_host_regs.sv
// Module: dw_host_regs
// Host-visible register file: write-side command registers, control bits,
// captured response and read multiplexer. Decodes the trigger address into a
// start request. Assumes wr_en/rd_en are already qualified by enable and
// direction, and that capture/cycle_end are single-cycle pulses.
module dw_host_regs
    import crate_regif_pkg::*;
#(
    parameter int unsigned ST_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [HOST_AW-1:0] addr,
    input  logic [HOST_DW-1:0] wdata,
    output logic [HOST_DW-1:0] rdata,
    output logic               start_req,
    input  logic               capture,
    input  logic               cycle_end,
    input  logic               done,
    input  logic               aux_state,
    input  logic [WORD_W-1:0]  dw_rdata,
    input  logic               dw_q,
    input  logic               dw_x,
    input  logic               lam_any,
    input  logic [ST_W-1:0]    lam_code,
    output logic [WORD_W-1:0]  wword,
    output logic [SUBA_W-1:0]  sub_a,
    output logic [FUNC_W-1:0]  func_f,
    output logic [ST_W-1:0]    stat_n,
    output logic               ctl_z,
    output logic               ctl_c,
    output logic               ctl_i,
    output logic               ctl_auxh
);

    logic [WORD_W-1:0] rd_word;
    logic              rd_q;
    logic              rd_x;

    assign start_req = wr_en && (addr == AD_GO);

    // Command registers loaded by host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wword  <= '0;
            sub_a  <= '0;
            func_f <= '0;
            stat_n <= '0;
        end else if (wr_en) begin
            unique case (addr)
                AD_WHI:  wword[23:16] <= wdata;
                AD_WMID: wword[15:8]  <= wdata;
                AD_WLO:  wword[7:0]   <= wdata;
                AD_SUBA: sub_a        <= wdata[SUBA_W-1:0];
                AD_FUNC: func_f       <= wdata[FUNC_W-1:0];
                AD_STAT: stat_n       <= wdata[ST_W-1:0];
                default: ;
            endcase
        end
    end

    // Control bits; cycle end clears Z and C ahead of any host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_z    <= 1'b0;
            ctl_c    <= 1'b0;
            ctl_i    <= 1'b0;
            ctl_auxh <= 1'b0;
        end else begin
            if (wr_en && addr == AD_CTRL) begin
                ctl_z    <= wdata[0];
                ctl_c    <= wdata[1];
                ctl_i    <= wdata[2];
                ctl_auxh <= wdata[3];
            end
            if (cycle_end) begin
                ctl_z <= 1'b0;
                ctl_c <= 1'b0;
            end
        end
    end

    // Response capture at the end of the first strobe phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_word <= '0;
            rd_q    <= 1'b0;
            rd_x    <= 1'b0;
        end else if (capture) begin
            rd_word <= dw_rdata;
            rd_q    <= dw_q;
            rd_x    <= dw_x;
        end
    end

    // Read multiplexer; unreadable addresses and idle bus return zero.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (addr)
                AD_RESP: rdata = {rd_q, rd_x, lam_any, lam_code};
                AD_RHI:  rdata = rd_word[23:16];
                AD_RMID: rdata = rd_word[15:8];
                AD_RLO:  rdata = rd_word[7:0];
                AD_STS:  rdata = {6'b0, aux_state, done};
                default: rdata = '0;
            endcase
        end
    end

    assert_zc_selfclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end |=> (!ctl_z && !ctl_c));

    assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (rd_word == $past(dw_rdata) && rd_q == $past(dw_q)
                     && rd_x == $past(dw_x)));

    assert_resp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(rd_word));

    assert_idle_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));

endmodule

// File: rtl/crate_regif_top.sv
// Module: crate_regif_top
// Host register interface and cycle sequencer of a crate controller.
// Qualifies host accesses, holds the command and response registers, runs
// one fixed-phase dataway cycle per trigger write and encodes the LAMs.
// Assumes all inputs are synchronous to clk.
module crate_regif_top
    import crate_regif_pkg::*;
#(
    parameter int unsigned N_STATIONS = 23,
    parameter int unsigned T_SETUP    = 2,
    parameter int unsigned T_S1       = 2,
    parameter int unsigned T_S2       = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_en_n,
    input  logic                  host_rd_wn,
    input  logic                  host_wstb,
    input  logic [3:0]            host_addr,
    input  logic [7:0]            host_wdata,
    output logic [7:0]            host_rdata,
    output logic [4:0]            dw_n,
    output logic [3:0]            dw_a,
    output logic [4:0]            dw_f,
    output logic [23:0]           dw_wdata,
    input  logic [23:0]           dw_rdata,
    input  logic                  dw_q,
    input  logic                  dw_x,
    output logic                  dw_s1,
    output logic                  dw_s2,
    output logic                  dw_busy,
    output logic                  dw_z,
    output logic                  dw_c,
    output logic                  dw_i,
    output logic                  dw_aux_hold,
    input  logic [N_STATIONS-1:0] dw_lam,
    input  logic                  aux_state,
    output logic                  lam_flag
);

    localparam int unsigned ST_W = $clog2(N_STATIONS + 1);

    logic            wr_en;
    logic            rd_en;
    logic            start_req;
    logic            capture;
    logic            cycle_end;
    logic            done;
    logic            lam_any;
    logic [ST_W-1:0] lam_code;

    // Host access qualification.
    assign wr_en = !host_en_n && !host_rd_wn && host_wstb;
    assign rd_en = !host_en_n &&  host_rd_wn;

    assign lam_flag = lam_any;

    dw_host_regs #(.ST_W(ST_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (host_addr),
        .wdata     (host_wdata),
        .rdata     (host_rdata),
        .start_req (start_req),
        .capture   (capture),
        .cycle_end (cycle_end),
        .done      (done),
        .aux_state (aux_state),
        .dw_rdata  (dw_rdata),
        .dw_q      (dw_q),
        .dw_x      (dw_x),
        .lam_any   (lam_any),
        .lam_code  (lam_code),
        .wword     (dw_wdata),
        .sub_a     (dw_a),
        .func_f    (dw_f),
        .stat_n    (dw_n),
        .ctl_z     (dw_z),
        .ctl_c     (dw_c),
        .ctl_i     (dw_i),
        .ctl_auxh  (dw_aux_hold)
    );

    dw_cycle_seq #(.T_SETUP(T_SETUP), .T_S1(T_S1), .T_S2(T_S2)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .busy      (dw_busy),
        .s1        (dw_s1),
        .s2        (dw_s2),
        .capture   (capture),
        .cycle_end (cycle_end),
        .done      (done)
    );

    lam_prio_enc #(.N_ST(N_STATIONS), .ST_W(ST_W)) lam_i (
        .clk   (clk),
        .rst_n (rst_n),
        .lam   (dw_lam),
        .any   (lam_any),
        .code  (lam_code)
    );

    // Writes to command registers must not disturb an unrelated port.
    assert_inhibit_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && host_addr == AD_CTRL) |=> $stable(dw_i) && $stable(dw_aux_hold));

    assert_cmd_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(dw_wdata) && $stable(dw_n) && $stable(dw_a) && $stable(dw_f)));

endmodule

// File: tb/crate_regif_top_tb_top.sv
module crate_regif_top_tb_top;

    localparam int TS  = 2;
    localparam int T1  = 2;
    localparam int T2  = 2;
    localparam int TOT = TS + T1 + T2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_en_n = 1'b1;
    logic        host_rd_wn = 1'b1;
    logic        host_wstb = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [4:0]  dw_n;
    logic [3:0]  dw_a;
    logic [4:0]  dw_f;
    logic [23:0] dw_wdata;
    logic [23:0] dw_rdata = '0;
    logic        dw_q = 1'b0;
    logic        dw_x = 1'b0;
    logic        dw_s1, dw_s2, dw_busy, dw_z, dw_c, dw_i, dw_aux_hold;
    logic [22:0] dw_lam = '0;
    logic        aux_state = 1'b0;
    logic        lam_flag;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    crate_regif_top #(.N_STATIONS(23), .T_SETUP(TS), .T_S1(T1), .T_S2(T2)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_en_n(host_en_n), .host_rd_wn(host_rd_wn),
        .host_wstb(host_wstb), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .dw_n(dw_n), .dw_a(dw_a), .dw_f(dw_f),
        .dw_wdata(dw_wdata), .dw_rdata(dw_rdata), .dw_q(dw_q), .dw_x(dw_x),
        .dw_s1(dw_s1), .dw_s2(dw_s2), .dw_busy(dw_busy), .dw_z(dw_z), .dw_c(dw_c),
        .dw_i(dw_i), .dw_aux_hold(dw_aux_hold), .dw_lam(dw_lam),
        .aux_state(aux_state), .lam_flag(lam_flag)
    );

    // LAM table: {lam lines, expected station code}.
    localparam int NV = 6;
    localparam logic [27:0] LAM_TBL [NV] = '{
        {23'h000000, 5'd0},
        {23'h000001, 5'd1},
        {23'h400000, 5'd23},
        {23'h400010, 5'd5},
        {23'h7FFFFF, 5'd1},
        {23'h001100, 5'd9}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_en_n = 1'b0; host_rd_wn = 1'b0; host_wstb = 1'b1;
        host_addr = a; host_wdata = d;
        @(negedge clk);
        host_en_n = 1'b1; host_rd_wn = 1'b1; host_wstb = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [7:0] d);
        host_en_n = 1'b0; host_rd_wn = 1'b1; host_wstb = 1'b0; host_addr = a;
        #1 d = host_rdata;
        host_en_n = 1'b1;
    endtask

    task automatic hread(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        peek(a, d);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        peek(4'd12, d); chk("R7 reset status", d, 8'h00);
        chk("R4 reset busy", {dw_busy, dw_s1, dw_s2}, 3'b000);
        chk("R1 reset wdata", dw_wdata, 24'h0);
        chk("R3 reset ctrl", {dw_z, dw_c, dw_i, dw_aux_hold}, 4'h0);

        // Table walk: LAM encoding
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            dw_lam = LAM_TBL[v][27:5];
            peek(4'd8, d);
            chk("R8 lam code", d[4:0], LAM_TBL[v][4:0]);
            chk("R8 lam any", {d[5], lam_flag}, (LAM_TBL[v][27:5] != 0) ? 2'b11 : 2'b00);
        end
        dw_lam = '0;

        // Command registers
        hwrite(4'd0, 8'hA1); hwrite(4'd1, 8'hB2); hwrite(4'd2, 8'hC3);
        chk("R1 write word", dw_wdata, 24'hA1B2C3);
        hwrite(4'd3, 8'hF9); hwrite(4'd4, 8'hFA); hwrite(4'd5, 8'hF7);
        chk("R2 sub a", dw_a, 4'h9);
        chk("R2 func f", dw_f, 5'h1A);
        chk("R2 station n", dw_n, 5'h17);
        hwrite(4'd6, 8'h07);
        chk("R3 ctrl bits", {dw_z, dw_c, dw_i, dw_aux_hold}, 4'b1110);

        // Ignored accesses
        @(negedge clk);
        host_en_n = 1'b1; host_rd_wn = 1'b0; host_wstb = 1'b1; host_addr = 4'd5; host_wdata = 8'h03;
        @(negedge clk);
        host_en_n = 1'b0; host_rd_wn = 1'b1;
        @(negedge clk);
        host_en_n = 1'b1; host_wstb = 1'b0;
        chk("R10 ignored writes", dw_n, 5'h17);
        hread(4'd0, d); chk("R10 addr0 reads zero", d, 8'h00);
        hread(4'd15, d); chk("R10 addr15 reads zero", d, 8'h00);
        host_addr = 4'd12; #1 chk("R10 idle bus", host_rdata, 8'h00);

        // Cycle 1
        dw_rdata = 24'h5AC33C; dw_q = 1'b1; dw_x = 1'b0;
        hwrite(4'd7, 8'h00);
        chk("R4 busy after trigger", {dw_busy, dw_s1, dw_s2}, 3'b100);
        chk("R3 z during cycle", dw_z, 1'b1);
        repeat (TS) @(negedge clk);
        chk("R4 s1 phase", {dw_busy, dw_s1, dw_s2}, 3'b110);
        repeat (T1) @(negedge clk);
        chk("R4 s2 phase", {dw_busy, dw_s1, dw_s2}, 3'b101);
        dw_rdata = 24'h111111; dw_q = 1'b0; dw_x = 1'b1;
        peek(4'd12, d); chk("R7 complete low in cycle", d[0], 1'b0);
        repeat (T2) @(negedge clk);
        chk("R4 cycle end", {dw_busy, dw_s1, dw_s2}, 3'b000);
        chk("R6 z c cleared, i kept", {dw_z, dw_c, dw_i}, 3'b001);
        peek(4'd12, d); chk("R7 complete set", d, 8'h01);
        hread(4'd9, d);  chk("R5 read hi", d, 8'h5A);
        hread(4'd10, d); chk("R5 read mid", d, 8'hC3);
        hread(4'd11, d); chk("R5 read lo", d, 8'h3C);
        hread(4'd8, d);  chk("R5 q x", d[7:6], 2'b10);
        aux_state = 1'b1;
        hread(4'd12, d); chk("R7 aux bit", d, 8'h03);

        // Cycle 2 with a repeated trigger during the cycle
        dw_rdata = 24'h0F0E0D; dw_q = 1'b0; dw_x = 1'b1;
        hwrite(4'd7, 8'h00);
        peek(4'd12, d); chk("R7 complete cleared at start", d[0], 1'b0);
        hwrite(4'd7, 8'h00);
        repeat (TOT - 3) @(negedge clk);
        chk("R9 still busy before end", dw_busy, 1'b1);
        @(negedge clk);
        chk("R9 ends at original time", dw_busy, 1'b0);
        repeat (2) @(negedge clk);
        chk("R9 no restart", dw_busy, 1'b0);
        hread(4'd11, d); chk("R5 second capture", d, 8'h0D);
        hread(4'd8, d);  chk("R5 second q x", d[7:6], 2'b01);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule